// File: doc/BRIEF.md
# Address-Strobed Control Latch

This block is a peripheral control register that a processor programs with a single bus access and no data-bus traffic. It watches the address bus for accesses to one 256-byte page. An access to that page loads the register from the address bits alone. A plain read therefore changes the register just as a write does, and one instruction is enough to update it.

The block has two modes, fixed by a parameter. In byte mode, any access to the page copies the low eight address bits into the 8-bit register. In bit mode, the block works as an addressable latch. Sixteen offsets in the page each set or clear one register bit, and the other bits keep their values. Each register update also produces a one-cycle pulse, so logic further down can react to it.

Top module: `addr_ctrl_latch`

## Requirements
- R1: After the asynchronous active-low reset, the register output is 0x00 and the update pulse is low.
- R2: An access is decoded only when the valid input is high and addr_i[15:8] equals the page parameter (default 0x7C). The register does not change on an access to any other page or on a cycle with valid low.
- R3: In byte mode (BIT_MODE=0), a decoded access loads addr_i[7:0] into the register on the next rising clock edge.
- R4: The write-enable/data input is ignored. A read (we_i=0) and a write (we_i=1) with the same address update the register identically.
- R5: In bit mode (BIT_MODE=1), a decoded access with offset bits [7:4]=0 updates bit addr_i[2:0] of the register. The bit is set to 1 when addr_i[3]=1 and cleared to 0 when addr_i[3]=0. All other bits are unchanged.
- R6: In bit mode, a decoded access with any of offset bits [7:4] nonzero leaves the register unchanged and raises no pulse.
- R7: upd_o is high for exactly the one cycle after each edge at which the register was written. It is low otherwise, including after ignored accesses.
- R8: Back-to-back decoded accesses on consecutive cycles each take effect, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address bus carries a valid access this cycle |
| we_i | input | 1 | Access direction (ignored by the block) |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Data bus (ignored by the block) |
| latch_o | output | 8 | Register value |
| upd_o | output | 1 | One-cycle pulse after each register update |

## Verification
The assertions assume that valid_i and addr_i are settled at each rising clock edge and are never unknown out of reset. They also assume that the mode does not change while the block runs, since it is a parameter. The stimulus drives every input on the falling edge. It mixes random addresses, a random valid flag, random direction and random data with page-hitting addresses, so decoded, ignored and back-to-back accesses all occur. Both modes are covered by two instances in one bench.

// File: rtl/addr_ctrl_latch_pkg.sv
package addr_ctrl_latch_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned OFF_W  = 8;
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } latch_op_e;

  typedef struct packed {
    latch_op_e          op;
    logic [OFF_W-1:0]   value;
    logic [SEL_W-1:0]   sel;
  } latch_cmd_t;
endpackage

// File: rtl/acl_page_decode.sv
module acl_page_decode
  import addr_ctrl_latch_pkg::*;
#(
  parameter logic [PAGE_W-1:0] PAGE = 8'h7C
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OFF_W-1:0]  off_o
);
  assign hit_o = valid_i && (addr_i[ADDR_W-1:OFF_W] == PAGE);
  assign off_o = addr_i[OFF_W-1:0];
endmodule

// File: rtl/acl_cmd_gen.sv
module acl_cmd_gen
  import addr_ctrl_latch_pkg::*;
#(
  parameter bit BIT_MODE = 1'b0
) (
  input  logic             hit_i,
  input  logic [OFF_W-1:0] off_i,
  output latch_cmd_t       cmd_o
);
  generate
    if (BIT_MODE) begin : g_bit
      // offset 0000_psss : p=polarity, sss=bit index
      logic cmd_ok;
      assign cmd_ok = hit_i && (off_i[OFF_W-1:SEL_W+1] == '0);
      always_comb begin
        cmd_o.value = off_i;
        cmd_o.sel   = off_i[SEL_W-1:0];
        if (!cmd_ok)           cmd_o.op = OP_NONE;
        else if (off_i[SEL_W]) cmd_o.op = OP_SET;
        else                   cmd_o.op = OP_CLEAR;
      end
    end else begin : g_byte
      always_comb begin
        cmd_o.value = off_i;
        cmd_o.sel   = off_i[SEL_W-1:0];
        cmd_o.op    = hit_i ? OP_LOAD : OP_NONE;
      end
    end
  endgenerate
endmodule

// File: rtl/acl_latch_reg.sv
module acl_latch_reg
  import addr_ctrl_latch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  latch_cmd_t        cmd_i,
  output logic [DATA_W-1:0] q_o,
  output logic              upd_o
);
  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    unique case (cmd_i.op)
      OP_LOAD:  q_d = cmd_i.value[DATA_W-1:0];
      OP_SET:   q_d[cmd_i.sel] = 1'b1;
      OP_CLEAR: q_d[cmd_i.sel] = 1'b0;
      default:  q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= '0;
      upd_o <= 1'b0;
    end else begin
      q_o   <= q_d;
      upd_o <= (cmd_i.op != OP_NONE);
    end
  end

  assert_quiet_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.op == OP_NONE) |=> ($stable(q_o) && !upd_o));
  assert_pulse_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.op != OP_NONE) |=> upd_o);
  assert_set_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.op == OP_SET) |=> q_o[$past(cmd_i.sel)]);
  assert_clear_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.op == OP_CLEAR) |=> !q_o[$past(cmd_i.sel)]);
  assert_bit_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.op inside {OP_SET, OP_CLEAR}) |=> ($countones(q_o ^ $past(q_o)) <= 1));
endmodule

// File: rtl/addr_ctrl_latch.sv
module addr_ctrl_latch
  import addr_ctrl_latch_pkg::*;
#(
  parameter bit                BIT_MODE = 1'b0,
  parameter logic [PAGE_W-1:0] PAGE     = 8'h7C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] latch_o,
  output logic              upd_o
);
  logic             hit;
  logic [OFF_W-1:0] off;
  latch_cmd_t       cmd;

  // direction and data bus take no part in the update
  logic unused_bus;
  assign unused_bus = ^{we_i, wdata_i};

  acl_page_decode #(.PAGE(PAGE)) i_dec (
    .valid_i (valid_i),
    .addr_i  (addr_i),
    .hit_o   (hit),
    .off_o   (off)
  );

  acl_cmd_gen #(.BIT_MODE(BIT_MODE)) i_cmd (
    .hit_i (hit),
    .off_i (off),
    .cmd_o (cmd)
  );

  acl_latch_reg i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .q_o    (latch_o),
    .upd_o  (upd_o)
  );

  assert_off_page_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || addr_i[ADDR_W-1:OFF_W] != PAGE) |=> ($stable(latch_o) && !upd_o));
  assert_pulse_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(latch_o));

  generate
    if (!BIT_MODE) begin : g_byte_chk
      assert_byte_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && addr_i[ADDR_W-1:OFF_W] == PAGE) |=> (latch_o == $past(addr_i[OFF_W-1:0])));
    end else begin : g_bit_chk
      assert_bad_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && addr_i[ADDR_W-1:OFF_W] == PAGE && addr_i[OFF_W-1:SEL_W+1] != '0)
        |=> ($stable(latch_o) && !upd_o));
    end
  endgenerate
endmodule

// File: tb/test_addr_ctrl_latch.sv
module test_addr_ctrl_latch;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PG = 8'h7C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] q_byte, q_bit;
  logic upd_byte, upd_bit;
  int errors = 0, checks = 0;
  logic [7:0] exp_byte = '0, exp_bit = '0;
  logic exp_ub = 1'b0, exp_ui = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_ctrl_latch #(.BIT_MODE(1'b0), .PAGE(PG)) i_addr_ctrl_latch (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .latch_o(q_byte), .upd_o(upd_byte));

  addr_ctrl_latch #(.BIT_MODE(1'b1), .PAGE(PG)) i_addr_ctrl_latch_bit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .latch_o(q_bit), .upd_o(upd_bit));

  function automatic logic hit_f(logic v, logic [15:0] a);
    return v && (a[15:8] == PG);
  endfunction

  function automatic logic [7:0] next_byte(logic v, logic [15:0] a, logic [7:0] cur);
    return hit_f(v, a) ? a[7:0] : cur;
  endfunction

  function automatic logic bit_ok(logic v, logic [15:0] a);
    return hit_f(v, a) && (a[7:4] == 4'h0);
  endfunction

  function automatic logic [7:0] next_bit(logic v, logic [15:0] a, logic [7:0] cur);
    logic [7:0] r = cur;
    if (bit_ok(v, a)) r[a[2:0]] = a[3];
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive on negedge, sample next negedge (one register stage)
  task automatic cycle(logic v, logic w, logic [15:0] a, logic [7:0] d, string req);
    valid = v; we = w; addr = a; wdata = d;
    exp_ub = hit_f(v, a);
    exp_ui = bit_ok(v, a);
    exp_byte = next_byte(v, a, exp_byte);
    exp_bit  = next_bit(v, a, exp_bit);
    @(negedge clk);
    chk({req, " byte latch"}, q_byte, exp_byte);
    chk({req, " bit latch"}, q_bit, exp_bit);
    chk({req, " R7 byte pulse"}, {7'b0, upd_byte}, {7'b0, exp_ub});
    chk({req, " R7 bit pulse"}, {7'b0, upd_bit}, {7'b0, exp_ui});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    chk("R1 reset byte", q_byte, 8'h00);
    chk("R1 reset bit", q_bit, 8'h00);
    chk("R1 reset pulse", {6'b0, upd_byte, upd_bit}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    cycle(1, 0, 16'h7CA5, 8'h00, "R3 read load");
    cycle(1, 1, 16'h7C3C, 8'hFF, "R4 write load");
    cycle(1, 0, 16'h7C3C, 8'h00, "R4 read same");
    cycle(0, 0, 16'h7C11, 8'h00, "R2 invalid");
    cycle(1, 0, 16'h7D11, 8'h00, "R2 off page");
    cycle(1, 0, 16'h7B11, 8'h00, "R2 off page low");
    cycle(1, 0, 16'h7C0D, 8'h00, "R5 set bit5");
    cycle(1, 1, 16'h7C0F, 8'h00, "R5 set bit7");
    cycle(1, 0, 16'h7C08, 8'h00, "R5 set bit0");
    cycle(1, 0, 16'h7C05, 8'h00, "R5 clear bit5");
    cycle(1, 0, 16'h7C18, 8'h00, "R6 bad offset");
    cycle(1, 0, 16'h7CF0, 8'h00, "R6 bad offset high");
    cycle(1, 0, 16'h7C00, 8'h00, "R8 b2b a");
    cycle(1, 0, 16'h7C09, 8'h00, "R8 b2b b");
    cycle(1, 0, 16'h7C0A, 8'h00, "R8 b2b c");
    cycle(1, 0, 16'h7CFF, 8'h00, "R3 all ones");
    cycle(1, 0, 16'h7C00, 8'h00, "R3 zero");

    for (int i = 0; i < 2000; i++) begin
      logic v, w;
      logic [15:0] a;
      logic [7:0] d;
      v = $urandom_range(0, 3) != 0;
      w = $urandom_range(0, 1) == 1;
      d = 8'($urandom);
      case ($urandom_range(0, 3))
        0: a = 16'($urandom);
        1: a = {PG, 8'($urandom)};
        default: a = {PG, 4'h0, 4'($urandom)};
      endcase
      cycle(v, w, a, d, "R8 random");
    end

    valid = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule